// File: doc/BRIEF.md
# Camera Lane Receiver Control Registers

This block is the software-visible register file of a camera serial receiver front end. A processor reaches it over a plain read/write register bus. Through it the processor sets each lane's enable bit and settle count, sets a global enable with a lane power mask, holds a soft reset and picks combo operation. Each lane's receiver sends single-cycle event pulses. These are latched into sticky per-lane status bits, gated by per-lane masks, and merged into a single interrupt line.

Clearing status takes several steps. Writing a lane's clear register only arms the bits to be dropped. The drop happens when software raises bit 0 of the interrupt command register from 0 to 1. Software then lowers the command bit and writes the clear register back to zero. The lane configuration words repeat every 0x40 bytes, so with the default of five lanes the last configuration word ends below the global registers.

Top module: `lane_phy_regfile`

## Requirements
- R1: After reset, every writable register reads 0, and `lane_en`, `settle_cnt`, `soft_rst`, `combo_mode` and `irq` are all 0.
- R2: A read request returns its data on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request. The read-only version register at 0x188 returns the 8-bit `HW_VER` parameter, and writes to it change nothing.
- R3: Lane n has an enable word at 0x004 + 0x40·n and a settle word at 0x008 + 0x40·n. Bit 4 of the enable word is the lane enable. The 8-bit settle word drives `settle_cnt[8n+7:8n]`.
- R4: In the global reset register at 0x140, bit 0 drives `soft_rst` and bit 4 drives `combo_mode`. Both bits read back in place.
- R5: In the power register at 0x144, bit 0 is the global enable and bit n+1 is lane n's power bit. `lane_en[n]` is high only when lane n's enable bit, the global enable and lane n's power bit are all set.
- R6: A pulse on `lane_evt[6n+k]` sets bit k of lane n's status register at 0x18C + 4·n. The bit stays set until it is cleared.
- R7: Writing lane n's clear register at 0x1CC + 4·n only arms bits. No status bit changes until the command bit rises.
- R8: A write of 1 to bit 0 of the command register at 0x164, while that bit holds 0, drops every status bit whose clear bit is armed. Unarmed bits stay set. A write of 1 while the bit already holds 1 clears nothing.
- R9: An event pulse that arrives in the same cycle as a clearing command write leaves its status bit set.
- R10: `irq` is high exactly when some lane's status bit and the matching bit of its mask register at 0x1AC + 4·n are both set.
- R11: Unmapped addresses read as 0, and writes to them change no register. Status, mask and clear slots for lane indices at or above `NL` (up to slot 7) are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| lane_evt | input | NL*6 | Per-lane event pulses, six per lane |
| lane_en | output | NL | Effective lane enables |
| settle_cnt | output | NL*8 | Per-lane settle counts |
| soft_rst | output | 1 | Software reset level |
| combo_mode | output | 1 | Combo mode select |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that event pulses, whether or not they coincide with a command write, come straight from the lanes and are not held up by the bus. The stimulus drives the bus from tasks that do one access at a time, so read and write never overlap. Events are applied between accesses, except in one cycle that deliberately lines an event up with the clearing command write.

// File: rtl/lane_phy_regfile.sv
module lane_phy_regfile #(
  parameter int NL = 5,
  parameter int AW = 9,
  parameter logic [7:0] HW_VER = 8'h5A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            bus_rvalid,
  input  logic [NL*6-1:0] lane_evt,
  output logic [NL-1:0]   lane_en,
  output logic [NL*8-1:0] settle_cnt,
  output logic            soft_rst,
  output logic            combo_mode,
  output logic            irq
);
  localparam int EV = 6;
  localparam logic [AW-1:0] A_RST = AW'('h140);
  localparam logic [AW-1:0] A_PWR = AW'('h144);
  localparam logic [AW-1:0] A_CMD = AW'('h164);
  localparam logic [AW-1:0] A_VER = AW'('h188);
  localparam int A_STS = 'h18C;
  localparam int A_MSK = 'h1AC;
  localparam int A_CLR = 'h1CC;

  logic [NL-1:0]    cfg_en;
  logic [NL*8-1:0]  settle;
  logic [NL*EV-1:0] sts, msk, clr;
  logic             rst_bit, combo_bit, pwr_glbl, cmd;
  logic [NL-1:0]    pwr_mask;
  logic             cmd_rise;
  logic [31:0]      rd_mux;

  assign cmd_rise   = bus_wr && bus_addr == A_CMD && bus_wdata[0] && !cmd;
  assign lane_en    = cfg_en & pwr_mask & {NL{pwr_glbl}};
  assign settle_cnt = settle;
  assign soft_rst   = rst_bit;
  assign combo_mode = combo_bit;
  assign irq        = |(sts & msk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en <= '0; settle <= '0; msk <= '0; clr <= '0;
      rst_bit <= 1'b0; combo_bit <= 1'b0; pwr_glbl <= 1'b0;
      pwr_mask <= '0; cmd <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_RST) begin
        rst_bit   <= bus_wdata[0];
        combo_bit <= bus_wdata[4];
      end
      if (bus_addr == A_PWR) begin
        pwr_glbl <= bus_wdata[0];
        pwr_mask <= bus_wdata[NL:1];
      end
      if (bus_addr == A_CMD) cmd <= bus_wdata[0];
      for (int n = 0; n < NL; n++) begin
        if (bus_addr == AW'(n*64 + 4)) cfg_en[n] <= bus_wdata[4];
        if (bus_addr == AW'(n*64 + 8)) settle[n*8 +: 8] <= bus_wdata[7:0];
        if (bus_addr == AW'(A_MSK + 4*n)) msk[n*EV +: EV] <= bus_wdata[EV-1:0];
        if (bus_addr == AW'(A_CLR + 4*n)) clr[n*EV +: EV] <= bus_wdata[EV-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~(cmd_rise ? clr : '0)) | lane_evt;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_RST) rd_mux = {27'd0, combo_bit, 3'd0, rst_bit};
    if (bus_addr == A_PWR) rd_mux = 32'({pwr_mask, pwr_glbl});
    if (bus_addr == A_CMD) rd_mux = {31'd0, cmd};
    if (bus_addr == A_VER) rd_mux = {24'd0, HW_VER};
    for (int n = 0; n < NL; n++) begin
      if (bus_addr == AW'(n*64 + 4)) rd_mux = {27'd0, cfg_en[n], 4'd0};
      if (bus_addr == AW'(n*64 + 8)) rd_mux = {24'd0, settle[n*8 +: 8]};
      if (bus_addr == AW'(A_STS + 4*n)) rd_mux = {26'd0, sts[n*EV +: EV]};
      if (bus_addr == AW'(A_MSK + 4*n)) rd_mux = {26'd0, msk[n*EV +: EV]};
      if (bus_addr == AW'(A_CLR + 4*n)) rd_mux = {26'd0, clr[n*EV +: EV]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/lane_phy_regfile_chk.sv
module lane_phy_regfile_chk #(
  parameter int NL = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_rd,
  input logic            bus_rvalid,
  input logic            irq,
  input logic            pwr_glbl,
  input logic            cmd_rise,
  input logic [NL-1:0]   lane_en,
  input logic [NL*6-1:0] sts,
  input logic [NL*6-1:0] msk,
  input logic [NL*6-1:0] lane_evt
);
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_no_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  assert_lane_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_glbl |-> lane_en == '0);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rise |=> (sts & $past(sts)) == $past(sts));
  assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_evt) |=> (sts & $past(lane_evt)) == $past(lane_evt));
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|sts) && (|msk));
endmodule

bind lane_phy_regfile lane_phy_regfile_chk #(.NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .irq(irq), .pwr_glbl(pwr_glbl), .cmd_rise(cmd_rise), .lane_en(lane_en),
  .sts(sts), .msk(msk), .lane_evt(lane_evt)
);

// File: tb/sim_lane_phy_regfile.sv
`timescale 1ns/1ps
module sim_lane_phy_regfile;
  localparam int NL = 5;
  localparam int AW = 9;
  localparam logic [7:0] VER = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [NL*6-1:0] lane_evt = '0;
  logic [NL-1:0] lane_en;
  logic [NL*8-1:0] settle_cnt;
  logic soft_rst, combo_mode, irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  lane_phy_regfile #(.NL(NL), .AW(AW), .HW_VER(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .lane_evt(lane_evt), .lane_en(lane_en),
    .settle_cnt(settle_cnt), .soft_rst(soft_rst), .combo_mode(combo_mode),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check("R2 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = AW'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [NL*6-1:0] e);
    @(negedge clk); lane_evt = e;
    @(negedge clk); lane_evt = '0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lane_en", 32'(lane_en), 0);
    check("R1 settle", 32'(settle_cnt), 0);
    check("R1 irq/rst/combo", {29'd0, irq, soft_rst, combo_mode}, 0);
    rd('h144, 0, "R1 pwr reset");
    rd('h1AC, 0, "R1 mask reset");
    rd('h188, 32'(VER), "R2 version");
    wr('h188, 32'hFF);
    rd('h188, 32'(VER), "R2 version read-only");

    wr('h048, 32'h2B);
    check("R3 settle lane1", 32'(settle_cnt[15:8]), 32'h2B);
    rd('h048, 32'h2B, "R3 settle readback");
    wr('h044, 32'h10);
    rd('h044, 32'h10, "R3 enable readback");
    check("R5 no power", 32'(lane_en), 0);
    wr('h144, 32'h5);
    check("R5 lane1 on", 32'(lane_en), 32'h2);
    wr('h144, 32'h4);
    check("R5 no global", 32'(lane_en), 0);
    wr('h144, 32'h5);

    wr('h140, 32'h11);
    check("R4 rst/combo", {30'd0, soft_rst, combo_mode}, 32'h3);
    rd('h140, 32'h11, "R4 readback");
    wr('h140, 32'h10);
    check("R4 rst low", {30'd0, soft_rst, combo_mode}, 32'h1);

    pulse(30'(1) << 13);
    rd('h194, 32'h2, "R6 lane2 bit1");
    check("R10 unmasked no irq", 32'(irq), 0);
    pulse(30'(1) << 9);
    rd('h190, 32'h8, "R6 lane1 bit3 sticky");
    check("R10 still no irq", 32'(irq), 0);
    wr('h1B0, 32'h3F);
    check("R10 masked irq", 32'(irq), 1);

    wr('h1D0, 32'h3F);
    rd('h190, 32'h8, "R7 armed not cleared");
    wr('h164, 1);
    rd('h190, 32'h0, "R8 cleared on rise");
    rd('h194, 32'h2, "R8 unarmed kept");
    check("R10 irq gone", 32'(irq), 0);
    pulse(30'(1) << 6);
    wr('h164, 1);
    rd('h190, 32'h1, "R8 no clear while high");
    wr('h164, 0);
    wr('h1D0, 0);

    wr('h1D0, 32'h3F);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'('h164); bus_wdata = 1; lane_evt = 30'(1) << 11;
    @(negedge clk);
    bus_wr = 1'b0; lane_evt = '0;
    rd('h190, 32'h20, "R9 event wins");
    wr('h164, 0);
    wr('h1D0, 0);

    wr('h0C0, 32'hFF);
    rd('h0C0, 0, "R11 unmapped read");
    wr('h1C4, 32'h3F);
    rd('h1C4, 0, "R11 slot 6 mask");
    rd('h1A4, 0, "R11 slot 6 status");
    rd('h144, 32'h5, "R11 pwr untouched");

    repeat (3) @(negedge clk);
    check("R2 queue drained", 32'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule